// File: doc/BRIEF.md
# Return Stack with Flag Save

This block is the hardware return-address stack of a small 8-bit controller. The controller strobes `call_push` when a call instruction executes at program address `pc_in`, and the stack records `pc_in + 1`. On interrupt entry it strobes `irq_push`, and the stack records `pc_in + 1` together with the current carry and zero flags in the same entry. The top entry is always visible on `top_addr`, `top_carry` and `top_zero`, so the fetch stage can jump to it in the cycle it pops.

A plain return (`ret_pop`) drops the top entry and leaves the controller's flags alone. An interrupt return (`iret_pop`) drops the top entry and raises `flags_load` in that same cycle. The controller then copies `top_carry`/`top_zero` back into its flags. The pointer has no overflow or underflow detection. It wraps modulo the depth, and an overflowing push overwrites the oldest entry. At most one operation happens per cycle. When several strobes coincide, a fixed priority picks one of them.

Internally a decoder picks one operation from the enumerated set (none, call, interrupt entry, return, interrupt return). A pointer register is the only sequential state besides the entry storage. The storage is one register per entry.

Top module: `rstk_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `top_addr` reads 0, `top_carry` and `top_zero` read 0, and `flags_load` is 0.
- R2: A call push stores `(pc_in + 1) mod 2^AW` with both flag bits 0, whatever `carry_in`/`zero_in` are. After the clock edge `top_addr` shows that address, so 0xFFF wraps to 0x000 for AW=12.
- R3: An interrupt-entry push stores `(pc_in + 1) mod 2^AW`, `carry_in` and `zero_in` in one entry. After the edge these appear on `top_addr`, `top_carry` and `top_zero`.
- R4: A plain return keeps `flags_load` at 0 in its cycle, even when the top entry holds saved flags. After the edge the previous entry is on top.
- R5: An interrupt return raises `flags_load` in its own cycle, while `top_carry`/`top_zero` still show the popped entry's flags. After the edge the previous entry is on top. `flags_load` is never 1 without `iret_pop`.
- R6: Entries come back in last-in, first-out order.
- R7: Pushing DEPTH+1 entries wraps the pointer, so the newest entry replaces the oldest. Popping then yields the remaining DEPTH-1 older entries, and the newest entry comes back at the DEPTH-th pop.
- R8: Popping past the bottom wraps the pointer. After one push and DEPTH pops, the pushed entry is on top again.
- R9: When several strobes coincide, exactly one operation is done, in the priority irq_push > call_push > iret_pop > ret_pop. `flags_load` follows only a selected interrupt return.
- R10: In a cycle with no strobe, `top_addr`, `top_carry` and `top_zero` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| call_push | input | 1 | Call strobe: push the next address, no flags |
| irq_push | input | 1 | Interrupt-entry strobe: push the next address with flags |
| ret_pop | input | 1 | Plain return strobe |
| iret_pop | input | 1 | Interrupt return strobe |
| pc_in | input | AW | Address of the instruction being left |
| carry_in | input | 1 | Carry flag to save on interrupt entry |
| zero_in | input | 1 | Zero flag to save on interrupt entry |
| top_addr | output | AW | Return address held in the top entry |
| top_carry | output | 1 | Carry bit saved in the top entry |
| top_zero | output | 1 | Zero bit saved in the top entry |
| flags_load | output | 1 | Restore the flags from the top entry this cycle |

## Verification
Several push patterns are used. Call pushes with the flag inputs set show that the flag bits come from the push kind and not from the inputs. An address of all ones shows the increment wrapping. Interrupt pushes with mixed flag values show that carry and zero are kept apart. A nested mix of call and interrupt entries, unwound with both kinds of return, shows whether the flag restore strobe follows the return kind or the entry content. Runs longer than the depth in both directions show wrapping as opposed to saturation, and coincident strobes show the selection order.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

    // Operation chosen for the current cycle.
    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_CALL = 3'd1,
        OP_IRQ  = 3'd2,
        OP_RET  = 3'd3,
        OP_IRET = 3'd4
    } rstk_op_e;

endpackage

// File: rtl/rstk_decode.sv
module rstk_decode
    import rstk_pkg::*;
(
    input  logic     call_push,
    input  logic     irq_push,
    input  logic     ret_pop,
    input  logic     iret_pop,
    output rstk_op_e op
);

    // Fixed priority: interrupt entry, call, interrupt return, return.
    always_comb begin
        op = OP_NONE;
        unique casez ({irq_push, call_push, iret_pop, ret_pop})
            4'b1???: op = OP_IRQ;
            4'b01??: op = OP_CALL;
            4'b001?: op = OP_IRET;
            4'b0001: op = OP_RET;
            4'b0000: op = OP_NONE;
        endcase
    end

endmodule

// File: rtl/rstk_ptr.sv
module rstk_ptr #(
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    output logic [PW-1:0] wr_idx,
    output logic [PW-1:0] rd_idx
);

    logic [PW-1:0] sp_q;
    logic [PW-1:0] sp_d;

    // The depth is a power of two, so plain PW-bit arithmetic wraps.
    always_comb begin
        sp_d = sp_q;
        if (push)
            sp_d = sp_q + 1'b1;
        else if (pop)
            sp_d = sp_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sp_q <= '0;
        else
            sp_q <= sp_d;
    end

    assign wr_idx = sp_q;
    assign rd_idx = sp_q - 1'b1;

endmodule

// File: rtl/rstk_store.sv
module rstk_store #(
    parameter int DEPTH = 16,
    parameter int EW    = 14,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_idx,
    input  logic [EW-1:0] wr_data,
    input  logic [PW-1:0] rd_idx,
    output logic [EW-1:0] rd_data
);

    logic [DEPTH*EW-1:0] flat;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [EW-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= '0;
            else if (wr_en && (wr_idx == PW'(i)))
                q <= wr_data;
        end
        assign flat[i*EW +: EW] = q;
    end

    assign rd_data = flat[rd_idx*EW +: EW];

endmodule

// File: rtl/rstk_top.sv
module rstk_top
    import rstk_pkg::*;
#(
    parameter int DEPTH = 16,   // 8, 16 or 32
    parameter int AW    = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          call_push,
    input  logic          irq_push,
    input  logic          ret_pop,
    input  logic          iret_pop,
    input  logic [AW-1:0] pc_in,
    input  logic          carry_in,
    input  logic          zero_in,
    output logic [AW-1:0] top_addr,
    output logic          top_carry,
    output logic          top_zero,
    output logic          flags_load
);

    // Entry layout: [AW-1:0] address, [AW] carry, [AW+1] zero.
    localparam int EW  = AW + 2;
    localparam int PW  = $clog2(DEPTH);
    localparam int C_B = AW;
    localparam int Z_B = AW + 1;

    rstk_op_e      op;
    logic          do_push;
    logic          do_pop;
    logic [EW-1:0] wr_entry;
    logic [EW-1:0] top_entry;
    logic [PW-1:0] wr_idx;
    logic [PW-1:0] rd_idx;
    logic [AW-1:0] pc_next;

    assign pc_next = pc_in + 1'b1;

    rstk_decode u_decode (
        .call_push (call_push),
        .irq_push  (irq_push),
        .ret_pop   (ret_pop),
        .iret_pop  (iret_pop),
        .op        (op)
    );

    always_comb begin
        do_push    = 1'b0;
        do_pop     = 1'b0;
        flags_load = 1'b0;
        wr_entry   = '0;
        unique case (op)
            OP_NONE: ;
            OP_CALL: begin
                do_push  = 1'b1;
                wr_entry = {1'b0, 1'b0, pc_next};
            end
            OP_IRQ: begin
                do_push  = 1'b1;
                wr_entry = {zero_in, carry_in, pc_next};
            end
            OP_RET: begin
                do_pop = 1'b1;
            end
            OP_IRET: begin
                do_pop     = 1'b1;
                flags_load = 1'b1;
            end
            default: ;
        endcase
    end

    rstk_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (do_push),
        .pop    (do_pop),
        .wr_idx (wr_idx),
        .rd_idx (rd_idx)
    );

    rstk_store #(.DEPTH(DEPTH), .EW(EW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (do_push),
        .wr_idx  (wr_idx),
        .wr_data (wr_entry),
        .rd_idx  (rd_idx),
        .rd_data (top_entry)
    );

    assign top_addr  = top_entry[AW-1:0];
    assign top_carry = top_entry[C_B];
    assign top_zero  = top_entry[Z_B];

endmodule

// File: rtl/rstk_chk.sv
module rstk_chk #(
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          call_push,
    input logic          irq_push,
    input logic          ret_pop,
    input logic          iret_pop,
    input logic [AW-1:0] pc_in,
    input logic          carry_in,
    input logic          zero_in,
    input logic [AW-1:0] top_addr,
    input logic          top_carry,
    input logic          top_zero,
    input logic          flags_load
);

    logic [AW-1:0] nxt;
    logic          any_strobe;
    logic          only_call;
    logic          only_ret;

    assign nxt        = pc_in + 1'b1;
    assign any_strobe = call_push | irq_push | ret_pop | iret_pop;
    assign only_call  = call_push & !irq_push;
    assign only_ret   = ret_pop & !call_push & !irq_push & !iret_pop;

    p_reset_empty_r1: assert property (@(posedge clk)
        !rst_n |=> (top_addr == '0 && !top_carry && !top_zero));

    p_call_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        only_call |=> (top_addr == $past(nxt) && !top_carry && !top_zero));

    p_irq_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_push |=> (top_addr == $past(nxt) && top_carry == $past(carry_in)
                      && top_zero == $past(zero_in)));

    p_ret_no_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        only_ret |-> !flags_load);

    p_iret_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (iret_pop && !call_push && !irq_push) |-> flags_load);

    p_load_needs_iret_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flags_load |-> iret_pop);

    p_push_pop_restores_r6: assert property (@(posedge clk) disable iff (!rst_n)
        only_call ##1 only_ret |=> (top_addr == $past(top_addr, 2)));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !any_strobe |=> ($stable(top_addr) && $stable(top_carry) && $stable(top_zero)));

endmodule

bind rstk_top rstk_chk #(.AW(AW)) u_chk (.*);

// File: tb/test_rstk_top.sv
module test_rstk_top;

    localparam int PERIOD = 10;
    localparam int DEPTH  = 16;
    localparam int AW     = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          call_push = 1'b0;
    logic          irq_push = 1'b0;
    logic          ret_pop = 1'b0;
    logic          iret_pop = 1'b0;
    logic [AW-1:0] pc_in = '0;
    logic          carry_in = 1'b0;
    logic          zero_in = 1'b0;
    logic [AW-1:0] top_addr;
    logic          top_carry;
    logic          top_zero;
    logic          flags_load;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic got_ld, got_c, got_z;

    always #(PERIOD/2) clk = ~clk;

    rstk_top #(.DEPTH(DEPTH), .AW(AW)) i_rstk_top (.*);

    function automatic logic [AW-1:0] nx(input logic [AW-1:0] pc);
        return pc + 1'b1;
    endfunction

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        {call_push, irq_push, ret_pop, iret_pop} = 4'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    // Drive strobes at a falling edge, capture the combinational
    // outputs before the rising edge, release after it.
    task automatic step(input logic c, input logic i, input logic r, input logic ir,
                        input logic [AW-1:0] pc, input logic cf, input logic zf);
        @(negedge clk);
        call_push = c; irq_push = i; ret_pop = r; iret_pop = ir;
        pc_in = pc; carry_in = cf; zero_in = zf;
        #1;
        got_ld = flags_load; got_c = top_carry; got_z = top_zero;
        @(posedge clk);
        #1;
        {call_push, irq_push, ret_pop, iret_pop} = 4'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 top_addr", top_addr, 0);
        chk("R1 flags", {top_carry, top_zero}, 0);
        chk("R1 flags_load", flags_load, 0);
    endtask

    task automatic t_call();
        do_reset();
        step(1, 0, 0, 0, 12'h0FF, 1, 1);
        chk("R2 call addr", top_addr, 12'h100);
        chk("R2 call flags zero", {top_carry, top_zero}, 0);
        step(1, 0, 0, 0, 12'hFFF, 0, 0);
        chk("R2 addr wrap", top_addr, 12'h000);
    endtask

    task automatic t_irq_ret();
        do_reset();
        step(1, 0, 0, 0, 12'h040, 0, 0);
        step(0, 1, 0, 0, 12'h234, 1, 0);
        chk("R3 irq addr", top_addr, 12'h235);
        chk("R3 irq carry", top_carry, 1);
        chk("R3 irq zero", top_zero, 0);
        step(0, 0, 1, 0, 12'h000, 0, 0);
        chk("R4 ret no load", got_ld, 0);
        chk("R4 ret next top", top_addr, 12'h041);
    endtask

    task automatic t_iret();
        do_reset();
        step(1, 0, 0, 0, 12'h050, 1, 1);
        step(0, 1, 0, 0, 12'h060, 0, 1);
        step(0, 0, 0, 1, 12'h000, 0, 0);
        chk("R5 iret load", got_ld, 1);
        chk("R5 iret saved flags", {got_c, got_z}, 2'b01);
        chk("R5 iret next top", top_addr, 12'h051);
        chk("R5 call entry flags", {top_carry, top_zero}, 0);
    endtask

    task automatic t_lifo();
        do_reset();
        for (int k = 1; k <= 5; k++) step(1, 0, 0, 0, AW'(k * 16), 0, 0);
        for (int k = 5; k >= 1; k--) begin
            chk("R6 lifo", top_addr, nx(AW'(k * 16)));
            step(0, 0, 1, 0, 12'h000, 0, 0);
        end
    endtask

    task automatic t_idle();
        do_reset();
        step(0, 1, 0, 0, 12'h3C0, 1, 1);
        repeat (4) @(negedge clk);
        chk("R10 idle addr", top_addr, 12'h3C1);
        chk("R10 idle flags", {top_carry, top_zero}, 2'b11);
    endtask

    task automatic t_overflow();
        do_reset();
        for (int k = 0; k <= DEPTH; k++) step(1, 0, 0, 0, AW'(12'h100 + k), 0, 0);
        chk("R7 newest on top", top_addr, 12'h101 + DEPTH);
        step(0, 0, 1, 0, 12'h000, 0, 0);
        chk("R7 first pop", top_addr, 12'h100 + DEPTH);
        for (int k = 0; k < DEPTH - 2; k++) step(0, 0, 1, 0, 12'h000, 0, 0);
        chk("R7 oldest kept", top_addr, 12'h102);
        step(0, 0, 1, 0, 12'h000, 0, 0);
        chk("R7 wrapped to newest", top_addr, 12'h101 + DEPTH);
    endtask

    task automatic t_underflow();
        do_reset();
        step(1, 0, 0, 0, 12'h3A0, 0, 0);
        step(0, 0, 1, 0, 12'h000, 0, 0);
        chk("R8 below bottom", top_addr, 0);
        for (int k = 1; k < DEPTH; k++) step(0, 0, 1, 0, 12'h000, 0, 0);
        chk("R8 wrapped back", top_addr, 12'h3A1);
    endtask

    task automatic t_priority();
        do_reset();
        step(1, 0, 0, 0, 12'h010, 0, 0);
        step(1, 0, 0, 1, 12'h020, 1, 1);
        chk("R9 call over iret load", got_ld, 0);
        chk("R9 call over iret", top_addr, 12'h021);
        step(1, 1, 0, 0, 12'h030, 1, 1);
        chk("R9 irq over call", {top_zero, top_carry, top_addr}, {2'b11, 12'h031});
        step(0, 0, 1, 1, 12'h000, 0, 0);
        chk("R9 iret over ret load", got_ld, 1);
        chk("R9 single pop", top_addr, 12'h021);
    endtask

    initial begin
        t_reset();
        t_call();
        t_irq_ret();
        t_iret();
        t_lifo();
        t_idle();
        t_overflow();
        t_underflow();
        t_priority();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule